// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is a byte-wide I2C master that software steers through a small register window. Software places a byte in a transmit holding register. It then asks for bus conditions by setting request bits in a control byte. The sequencer moves each byte into a shift register, clocks it out MSB first with a ninth acknowledge clock, and creates START, repeated START, STOP and not-acknowledge conditions. It clears each request bit itself once the condition has been produced. When the address byte sent after a START has bit 0 set, the bytes that follow are read from the slave.

One down-counter reloads from a divisor register and produces a tick on each reload. While the master is enabled, every bus phase lasts one tick, so one SCL period spans two ticks. While the master is disabled, the same ticks can raise a periodic timer interrupt. Both bus lines are open-drain: an output enable of 1 pulls the line low.

Top module: `iic_cmd_seq`

## Requirements
- R1: After reset the control byte reads 0, the divisor reads 8, both line enables are 0 and both interrupts are low.
- R2: Writing the control byte with bit 7 (enable) at 0 clears the START, STOP and NAK requests in the same write, and from the next cycle both lines are released.
- R3: Writing 1 to bit 6 (START), bit 5 (STOP) or bit 2 (NAK) sets that request. Writing 0 to a request that is set leaves it set.
- R4: A START request with an empty transmit register causes no bus activity, and the request stays set until data is written.
- R5: A START condition (SDA falls while SCL is high) is followed by the transmit byte MSB first and a ninth clock in which the slave may pull SDA low. The START bit reads 0 once the byte has been taken into the shift register.
- R6: A STOP request takes effect after the current byte and its acknowledge clock. When STOP and START are both pending, the STOP is issued first and a new START follows. Each bit clears once its condition has been sent. A STOP requested while no transfer is under way is dropped at the next tick.
- R7: When the address byte has bit 0 at 1, the following bytes are received MSB first and the master acknowledges each one by pulling SDA low in the ninth clock. The last received byte reads at address 0.
- R8: With NAK set, the master leaves SDA released in the acknowledge clock of the byte being received and then clears NAK.
- R9: txIrq is high exactly when the master is enabled, bit 3 is set and the transmit register is empty. It is low in the cycle after a write to address 0.
- R10: While the master is disabled and bit 4 is set, timerIrq pulses for one cycle every divisor clock cycles. While the master is enabled, it stays low.
- R11: Address 0 writes the transmit register and reads the received byte. Address 1 is the control byte, and bits 1 and 0 are stored and read back. Addresses 2 and 3 are the low and high divisor bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register select |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr, combinational |
| sdaIn | input | 1 | Sensed SDA line level |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| txIrq | output | 1 | Transmit register empty interrupt |
| timerIrq | output | 1 | Spare timer pulse |

## Verification
Register reads are combinational, so they are due in the same cycle as the address. Writes land at the next clock edge, and the bench samples the result at the following falling edge, where txIrq must already be low. The timer pulses are counted over a fixed window of whole divisor periods, and the gap between two pulses must equal the divisor exactly. Bus results depend on the divisor, so cycle counts are not used for them. A line monitor decodes START, STOP and nine-bit frames from the SCL and SDA edges, and each check waits for a given number of decoded events with a timeout before it compares their order and values.

// File: rtl/iic_seq_pkg.sv
package iic_seq_pkg;
  localparam int DATA_W = 8;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_DIVL = 2'd2;
  localparam logic [1:0] A_DIVH = 2'd3;

  localparam int CB_EN    = 7;
  localparam int CB_START = 6;
  localparam int CB_STOP  = 5;
  localparam int CB_TMR   = 4;
  localparam int CB_TXI   = 3;
  localparam int CB_NAK   = 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_STA, ST_STB, ST_BLO, ST_BHI,
    ST_ALO, ST_AHI, ST_HOLD, ST_SPA, ST_SPB
  } busState_e;

  typedef struct packed {
    logic loadShift;
    logic shiftBit;
    logic commitRx;
  } dpStrobe_t;
endpackage

// File: rtl/iic_seq_dp.sv
module iic_seq_dp
  import iic_seq_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DIV_RESET = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  dpStrobe_t         strobe,
  input  logic              sdaIn,
  output logic              tick,
  output logic              txFull,
  output logic              txAddrRead,
  output logic              shiftMsb,
  output logic [DATA_W-1:0] rxData,
  output logic [DIV_W-1:0]  divisor
);
  logic [DIV_W-1:0]  baudCnt;
  logic [DATA_W-1:0] txData;
  logic [DATA_W-1:0] shiftQ;
  logic [DATA_W-1:0] shiftNext;
  logic [15:0]       divWide;

  assign divWide    = 16'(divisor);
  assign tick       = (baudCnt <= DIV_W'(1));
  assign shiftMsb   = shiftQ[DATA_W-1];
  assign txAddrRead = txData[0];
  assign shiftNext  = {shiftQ[DATA_W-2:0], sdaIn};

  // baud counter: one tick per reload, shared by bus timing and spare timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) baudCnt <= DIV_W'(DIV_RESET);
    else       baudCnt <= tick ? divisor : baudCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divisor <= DIV_W'(DIV_RESET);
    end else if (wrEn && wrAddr == A_DIVL) begin
      divisor <= DIV_W'({divWide[15:8], wrData});
    end else if (wrEn && wrAddr == A_DIVH) begin
      divisor <= DIV_W'({wrData, divWide[7:0]});
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData <= '0;
      txFull <= 1'b0;
    end else if (wrEn && wrAddr == A_DATA) begin
      txData <= wrData;
      txFull <= 1'b1;
    end else if (strobe.loadShift) begin
      txFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      rxData <= '0;
    end else begin
      if (strobe.loadShift)     shiftQ <= txData;
      else if (strobe.shiftBit) shiftQ <= shiftNext;
      if (strobe.commitRx)      rxData <= shiftNext;
    end
  end
endmodule

// File: rtl/iic_seq_ctl.sv
module iic_seq_ctl
  import iic_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tick,
  input  logic              txFull,
  input  logic              txAddrRead,
  input  logic              shiftMsb,
  output logic [7:0]        ctrlQ,
  output dpStrobe_t         strobe,
  output logic              sclOe,
  output logic              sdaOe
);
  localparam logic [2:0] LAST_BIT = 3'(DATA_W - 1);

  busState_e state, stNext;
  logic [2:0] bitCnt, cntNext;
  logic modeRx, modeNext, readReq, readNext;
  logic enQ, tmrEn, txiEn, auxA, auxB;
  logic startP, stopP, nakP;
  logic clrStart, clrStop, clrNak;
  logic ctrlWr, enNext;

  assign ctrlWr = wrEn && wrAddr == A_CTRL;
  assign enNext = ctrlWr ? wrData[CB_EN] : enQ;
  assign ctrlQ  = {enQ, startP, stopP, tmrEn, txiEn, nakP, auxA, auxB};

  // request bits: software sets, hardware clears, disable wipes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {enQ, tmrEn, txiEn, auxA, auxB} <= '0;
      {startP, stopP, nakP} <= '0;
    end else begin
      if (ctrlWr) {enQ, tmrEn, txiEn, auxA, auxB} <=
        {wrData[CB_EN], wrData[CB_TMR], wrData[CB_TXI], wrData[1], wrData[0]};
      startP <= enNext & (startP | (ctrlWr & wrData[CB_START])) & ~clrStart;
      stopP  <= enNext & (stopP  | (ctrlWr & wrData[CB_STOP]))  & ~clrStop;
      nakP   <= enNext & (nakP   | (ctrlWr & wrData[CB_NAK]))   & ~clrNak;
    end
  end

  always_comb begin
    stNext = state; cntNext = bitCnt; modeNext = modeRx; readNext = readReq;
    strobe = '0; clrStart = 1'b0; clrStop = 1'b0; clrNak = 1'b0;
    if (tick) begin
      unique case (state)
        ST_IDLE: if (stopP) clrStop = 1'b1;
                 else if (startP && txFull) stNext = ST_PRE;
        ST_PRE:  stNext = ST_STA;
        ST_STA:  stNext = ST_STB;
        ST_STB: begin
          strobe.loadShift = 1'b1; clrStart = 1'b1;
          modeNext = 1'b0; readNext = txAddrRead;
          cntNext = LAST_BIT; stNext = ST_BLO;
        end
        ST_BLO:  stNext = ST_BHI;
        ST_BHI: begin
          strobe.shiftBit = 1'b1;
          if (bitCnt == '0) begin
            strobe.commitRx = modeRx; stNext = ST_ALO;
          end else begin
            cntNext = bitCnt - 1'b1; stNext = ST_BLO;
          end
        end
        ST_ALO:  stNext = ST_AHI;
        ST_AHI, ST_HOLD: begin
          if (state == ST_AHI) begin
            modeNext = readReq;
            if (modeRx && nakP) clrNak = 1'b1;
          end
          if (stopP) stNext = ST_SPA;
          else if (startP) stNext = txFull ? ST_PRE : ST_HOLD;
          else if (modeNext) begin
            cntNext = LAST_BIT; stNext = ST_BLO;
          end else if (txFull) begin
            strobe.loadShift = 1'b1; cntNext = LAST_BIT; stNext = ST_BLO;
          end else stNext = ST_HOLD;
        end
        ST_SPA:  stNext = ST_SPB;
        ST_SPB: begin clrStop = 1'b1; stNext = ST_IDLE; end
        default: stNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; bitCnt <= '0; modeRx <= 1'b0; readReq <= 1'b0;
    end else if (!enQ) begin
      state <= ST_IDLE; modeRx <= 1'b0;
    end else begin
      state <= stNext; bitCnt <= cntNext; modeRx <= modeNext; readReq <= readNext;
    end
  end

  always_comb begin
    sclOe = 1'b0; sdaOe = 1'b0;
    unique case (state)
      ST_PRE, ST_HOLD:    sclOe = 1'b1;
      ST_STB, ST_SPB:     sdaOe = 1'b1;
      ST_SPA:             begin sclOe = 1'b1; sdaOe = 1'b1; end
      ST_BLO:             begin sclOe = 1'b1; sdaOe = !modeRx && !shiftMsb; end
      ST_BHI:             sdaOe = !modeRx && !shiftMsb;
      ST_ALO:             begin sclOe = 1'b1; sdaOe = modeRx && !nakP; end
      ST_AHI:             sdaOe = modeRx && !nakP;
      default:            ;
    endcase
  end
endmodule

// File: rtl/iic_cmd_seq.sv
module iic_cmd_seq
  import iic_seq_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DIV_RESET = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       txIrq,
  output logic       timerIrq
);
  dpStrobe_t        strobe;
  logic             tick, txFull, txAddrRead, shiftMsb;
  logic [7:0]       ctrlQ;
  logic [7:0]       rxData;
  logic [DIV_W-1:0] divisor;
  logic [15:0]      divWide;

  iic_seq_dp #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrAddr(regAddr), .wrData(regWrData),
    .strobe(strobe), .sdaIn(sdaIn), .tick(tick), .txFull(txFull),
    .txAddrRead(txAddrRead), .shiftMsb(shiftMsb), .rxData(rxData), .divisor(divisor)
  );

  iic_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrAddr(regAddr), .wrData(regWrData),
    .tick(tick), .txFull(txFull), .txAddrRead(txAddrRead), .shiftMsb(shiftMsb),
    .ctrlQ(ctrlQ), .strobe(strobe), .sclOe(sclOe), .sdaOe(sdaOe)
  );

  assign divWide  = 16'(divisor);
  assign txIrq    = ctrlQ[CB_EN] && ctrlQ[CB_TXI] && !txFull;
  assign timerIrq = !ctrlQ[CB_EN] && ctrlQ[CB_TMR] && tick;

  always_comb begin
    unique case (regAddr)
      A_DATA:  regRdData = rxData;
      A_CTRL:  regRdData = ctrlQ;
      A_DIVL:  regRdData = divWide[7:0];
      default: regRdData = divWide[15:8];
    endcase
  end
endmodule

// File: rtl/iic_cmd_seq_chk.sv
module iic_cmd_seq_chk
  import iic_seq_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [1:0]       regAddr,
  input logic             sclOe,
  input logic             sdaOe,
  input logic             txIrq,
  input logic             timerIrq,
  input logic [7:0]       ctrlQ,
  input logic [DIV_W-1:0] divisor
);
  p_pend_clr_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[CB_EN] |-> (!ctrlQ[CB_START] && !ctrlQ[CB_STOP] && !ctrlQ[CB_NAK]));

  p_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[CB_EN] |=> (!sclOe && !sdaOe));

  p_fill_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_DATA) |=> !txIrq);

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[CB_EN] |-> !timerIrq);

  p_gap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (timerIrq && divisor > DIV_W'(1)) |=> !timerIrq);
endmodule

bind iic_cmd_seq iic_cmd_seq_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .sclOe(sclOe), .sdaOe(sdaOe), .txIrq(txIrq), .timerIrq(timerIrq),
  .ctrlQ(ctrlQ), .divisor(divisor)
);

// File: tb/iic_cmd_seq_test.sv
module iic_cmd_seq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic sdaIn, sclOe, sdaOe, txIrq, timerIrq;

  always #10 clk = ~clk;

  iic_cmd_seq uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .sdaIn(sdaIn),
    .sclOe(sclOe), .sdaOe(sdaOe), .txIrq(txIrq), .timerIrq(timerIrq)
  );

  int checks = 0;
  int fails = 0;

  // ---- bus line model and monitor: START = -1, STOP = -2, frame = byte + 256*ackBit
  logic sclL, sdaL, slaveOe;
  logic prevScl = 1'b1, prevSda = 1'b1, pend = 1'b0;
  logic inFrame = 1'b0, readMode = 1'b0, slaveDone = 1'b0;
  int bitIdx = 0, byteNum = 0;
  logic [8:0] acc = '0;
  logic [7:0] slaveBytes [4];
  int evQ[$];

  assign sclL = !sclOe;
  assign sdaL = !(sdaOe || slaveOe);
  assign sdaIn = sdaL;
  assign slaveOe = inFrame && !slaveDone &&
    ((readMode && byteNum > 0 && bitIdx < 8) ? !slaveBytes[(byteNum - 1) % 4][7 - bitIdx]
                                              : (!(readMode && byteNum > 0) && bitIdx == 8));

  always @(negedge clk) begin
    if (sclL && prevScl && prevSda && !sdaL) begin
      evQ.push_back(-1); pend = 0; inFrame = 1; bitIdx = 0; byteNum = 0;
      readMode = 0; slaveDone = 0;
    end else if (sclL && prevScl && !prevSda && sdaL) begin
      evQ.push_back(-2); pend = 0; inFrame = 0;
    end else if (sclL && !prevScl) begin
      pend = 1;
    end else if (!sclL && prevScl && pend) begin
      pend = 0;
      if (inFrame) begin
        acc = {acc[7:0], prevSda};
        bitIdx++;
        if (bitIdx == 9) begin
          evQ.push_back(int'(acc[8:1]) + (acc[0] ? 256 : 0));
          if (byteNum == 0) readMode = acc[1];
          else if (readMode && acc[0]) slaveDone = 1;
          byteNum++; bitIdx = 0;
        end
      end
    end
    prevScl = sclL; prevSda = sdaL;
  end

  // ---- helpers
  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdData;
  endtask

  task automatic waitEvents(int n);
    for (int i = 0; i < 4000 && evQ.size() < n; i++) @(negedge clk);
  endtask

  task automatic waitTxEmpty();
    for (int i = 0; i < 4000 && !txIrq; i++) @(negedge clk);
  endtask

  function automatic int ev(int i);
    return (i < evQ.size()) ? evQ[i] : -99;
  endfunction

  // ---- scenarios
  task automatic testReset();
    logic [7:0] d;
    rd(2'd1, d); chk("R1 ctrl", d, 8'h00);
    rd(2'd2, d); chk("R1 div lo", d, 8'd8);
    rd(2'd3, d); chk("R1 div hi", d, 8'd0);
    chk("R1 lines", {sclOe, sdaOe}, 2'b00);
    chk("R1 irqs", {txIrq, timerIrq}, 2'b00);
  endtask

  task automatic testRegMap();
    logic [7:0] d;
    wr(2'd2, 8'h34); wr(2'd3, 8'h12);
    rd(2'd2, d); chk("R11 div lo", d, 8'h34);
    rd(2'd3, d); chk("R11 div hi", d, 8'h12);
    wr(2'd1, 8'h03); rd(2'd1, d); chk("R11 aux bits", d, 8'h03);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'd4); wr(2'd3, 8'd0);
  endtask

  task automatic testSticky();
    logic [7:0] d;
    int pulled = 0;
    evQ.delete();
    wr(2'd1, 8'hC4);                       // enable, START, NAK
    wr(2'd1, 8'h80);                       // zeros to START and NAK
    rd(2'd1, d); chk("R3 start/nak sticky", d, 8'hC4);
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (sclOe || sdaOe) pulled++; end
    chk("R4 no bus activity", pulled + evQ.size(), 0);
    rd(2'd1, d); chk("R4 start still pending", d[6], 1);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R2 requests cleared", d, 8'h00);
    @(negedge clk); chk("R2 lines released", {sclOe, sdaOe}, 2'b00);
    wr(2'd1, 8'hA0);                       // STOP while idle
    for (int i = 0; i < 20; i++) @(negedge clk);
    rd(2'd1, d); chk("R6 idle stop dropped", d, 8'h80);
    chk("R6 idle stop no bus", evQ.size(), 0);
  endtask

  task automatic testTx();
    logic [7:0] d;
    evQ.delete();
    wr(2'd1, 8'h88);
    chk("R9 empty irq", txIrq, 1);
    wr(2'd0, 8'hA4);
    chk("R9 irq low after write", txIrq, 0);
    wr(2'd1, 8'hC8);
    waitTxEmpty();
    rd(2'd1, d); chk("R5 start cleared", d[6], 0);
    wr(2'd0, 8'h3C);
    waitTxEmpty();
    wr(2'd1, 8'hA8);
    waitEvents(4);
    chk("R5 start cond", ev(0), -1);
    chk("R5 address frame", ev(1), 8'hA4);
    chk("R5 data frame", ev(2), 8'h3C);
    chk("R6 stop after byte", ev(3), -2);
    for (int i = 0; i < 20; i++) @(negedge clk);
    rd(2'd1, d); chk("R6 stop cleared", d, 8'h88);
  endtask

  task automatic testStopStart();
    logic [7:0] d;
    evQ.delete();
    wr(2'd0, 8'h50); wr(2'd1, 8'hC8);
    waitTxEmpty();
    wr(2'd0, 8'h11);
    waitTxEmpty();
    wr(2'd1, 8'hE8);                       // START and STOP during a byte
    wr(2'd0, 8'h52);
    waitTxEmpty();
    wr(2'd1, 8'hA8);
    waitEvents(7);
    chk("R6 first frame", ev(1), 8'h50);
    chk("R6 byte done before stop", ev(2), 8'h11);
    chk("R6 stop first", ev(3), -2);
    chk("R6 start second", ev(4), -1);
    chk("R6 frame after restart", ev(5), 8'h52);
    chk("R6 final stop", ev(6), -2);
    for (int i = 0; i < 20; i++) @(negedge clk);
    rd(2'd1, d); chk("R6 bits cleared", d, 8'h88);
  endtask

  task automatic testRead();
    logic [7:0] d;
    evQ.delete();
    slaveBytes[0] = 8'h5A; slaveBytes[1] = 8'hC3;
    wr(2'd0, 8'h91); wr(2'd1, 8'hC0);
    waitEvents(3);
    chk("R7 read address", ev(1), 8'h91);
    chk("R7 byte acked", ev(2), 8'h5A);
    wr(2'd1, 8'hA4);                       // STOP and NAK
    waitEvents(5);
    chk("R8 byte nak", ev(3), 256 + 8'hC3);
    chk("R8 stop after nak", ev(4), -2);
    rd(2'd0, d); chk("R7 received byte", d, 8'hC3);
    rd(2'd1, d); chk("R8 nak cleared", d, 8'h80);
  endtask

  task automatic testTimer();
    int pulses = 0, first = -1, second = -1;
    wr(2'd1, 8'h00); wr(2'd2, 8'd10);
    wr(2'd1, 8'h10);
    for (int i = 0; i < 30; i++) @(negedge clk);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (timerIrq) begin
        pulses++;
        if (first < 0) first = i; else if (second < 0) second = i;
      end
    end
    chk("R10 pulse count", pulses, 20);
    chk("R10 period", second - first, 10);
    wr(2'd1, 8'h90);
    pulses = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (timerIrq) pulses++; end
    chk("R10 silent when enabled", pulses, 0);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegMap();
    testSticky();
    testTx();
    testStopStart();
    testRead();
    testTimer();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule